// File: doc/BRIEF.md
# PDM-to-PCM Sinc Decimator

This block turns a one-bit pulse-density stream from a digital microphone into signed 24-bit PCM samples using a cascaded integrator-comb filter. Each accepted input bit counts as +1 when it is high and -1 when it is low. The bit passes through a chain of running-sum integrators. Once every R accepted bits, the chain is sampled, differenced by an equal number of comb stages, and scaled to 24 bits. One instance serves one microphone channel.

The filter order (1 to 5) and the decimation ratio (8 to 256, a power of two) are picked at run time through encoded fields. A second, narrow ratio field takes over when the downstream audio-correction path is in use; in that mode only 64, 128 and 256 are reachable. Integrator and comb stages beyond the selected order hold still and are skipped. Any change of the effective settings wipes the filter history, so each new setting starts from a clean state.

A small state machine runs the block, with three states:
- `ST_OFF`: idle, because the settings are invalid.
- `ST_ACC`: accumulating input bits.
- `ST_EMIT`: the one cycle in which the comb chain runs and the output register loads.

Its transitions are:
- Any state goes to `ST_ACC` or `ST_OFF` on a settings change, depending on whether the new settings are valid.
- `ST_ACC` goes to `ST_EMIT` when the R-th bit of a block is accepted.
- `ST_EMIT` always returns to `ST_ACC`.
- `ST_OFF` otherwise holds.

Top module: `pdm_sinc_decim`

## Requirements
- R1: Inputs map 1 to +1 and 0 to -1. The comb result is scaled so that full scale, plus or minus R^N for order N and R = 2^k, lands on plus or minus 2^23. The result is shifted left by 23-N*k when N*k is below 23, and shifted right arithmetically by N*k-23 otherwise. For example, order 1 at R=8 with six ones per eight bits gives 0x400000.
- R2: A scaled value of +2^23 saturates to 0x7FFFFF. A value of -2^23 is output as 0x800000.
- R3: `order_code` 1..5 selects that order, and 0 selects the default order 3. Codes 6..15 make the block produce no samples.
- R4: When `af_en`=0, `ratio_code` c in 1..6 selects R = 2^(c+2), so 1=8, 2=16, 3=32, 4=64, 5=128 and 6=256. Codes 0 and 7..15 produce no samples.
- R5: When `af_en`=1, `af_ratio` 1, 2 and 3 select R = 64, 128 and 256, and `ratio_code` is ignored. `af_ratio` 0 produces no samples.
- R6: After a clear, with constant ones, the first sample equals C(R+N-1, N) before scaling. Samples N onward are in steady state; for example, order 2 at R=8 gives 0x480000 and then 0x7FFFFF.
- R7: The integrators are 42 bits wide and wrap in two's complement, so order 5 at R=256 reaches full scale exactly.
- R8: Cycles with `pdm_valid`=0 change nothing, so gaps in the strobe leave every result unchanged.
- R9: A change of the effective order or ratio clears all integrator state, comb state and the bit counter. The bit presented in the change cycle is discarded.
- R10: `pcm_valid` is a single-cycle pulse. It appears two clock edges after the edge that accepted the R-th bit of a block.
- R11: `pcm_data` keeps its last value between pulses.
- R12: Reset drives `pcm_valid` and `pcm_data` to 0. The first cycle after reset is treated as a settings change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pdm_bit | input | 1 | One-bit density sample |
| pdm_valid | input | 1 | Strobe marking `pdm_bit` as a new sample |
| order_code | input | 4 | Encoded filter order |
| ratio_code | input | 4 | Encoded decimation ratio (used when `af_en`=0) |
| af_en | input | 1 | Selects the restricted ratio field |
| af_ratio | input | 2 | Encoded ratio 64/128/256 (used when `af_en`=1) |
| pcm_data | output | 24 | Signed two's-complement output sample |
| pcm_valid | output | 1 | One-cycle pulse when `pcm_data` is new |

## Verification
The bench checks the first sample after a clear against the binomial transient value for orders 2 and 3. A design with misordered stages, or with delays that do not start from zero, would give a different number there, even though its steady-state output could still be correct. Full-scale inputs at order 5 and ratio 256 test the integrator width and the positive clamp: too few bits would wrap to a large negative value, and a missing clamp would flip the sign. A settings change with a held bit in flight tests that history is wiped and the change-cycle bit is dropped; a leaky design would shift the next sample off full scale. The bench also uses a gapped strobe, the restricted ratio field overriding an invalid main field, and invalid codes. A design that ignored the strobe, read the wrong field, or ran while disabled would produce wrong values, or samples where none are allowed.

// File: rtl/pdm_sinc_pkg.sv
package pdm_sinc_pkg;
    localparam int ORDER_MAX = 5;
    localparam int DEF_ORDER = 3;
    localparam int LOG2_RMIN = 3;
    localparam int LOG2_RMAX = 8;
    localparam int AF_K_BASE = 5;
    localparam int OUT_W     = 24;
    localparam int ACC_W     = ORDER_MAX * LOG2_RMAX + 2;
    localparam int ORD_W     = $clog2(ORDER_MAX + 1);
    localparam int K_W       = $clog2(LOG2_RMAX + 1);
    localparam int NK_W      = $clog2(ORDER_MAX * LOG2_RMAX + 1);
    localparam int CNT_W     = LOG2_RMAX;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ACC,
        ST_EMIT
    } sinc_state_e;

    typedef struct packed {
        logic             ok;
        logic [ORD_W-1:0] order;
        logic [K_W-1:0]   k;
    } sinc_cfg_t;

    localparam sinc_cfg_t CFG_RST = '{ok: 1'b0, order: ORD_W'(DEF_ORDER), k: K_W'(LOG2_RMIN)};
endpackage

// File: rtl/sinc_cfg_decode.sv
module sinc_cfg_decode
    import pdm_sinc_pkg::*;
(
    input  logic [3:0] order_code,
    input  logic [3:0] ratio_code,
    input  logic       af_en,
    input  logic [1:0] af_ratio,
    output sinc_cfg_t  cfg
);
    localparam logic [3:0] RCODE_MAX = 4'(LOG2_RMAX - LOG2_RMIN + 1);

    always_comb begin
        cfg.ok    = 1'b1;
        cfg.order = ORD_W'(1);
        cfg.k     = K_W'(LOG2_RMIN);
        if (order_code == 4'd0) begin
            cfg.order = ORD_W'(DEF_ORDER);
        end else if (order_code <= 4'(ORDER_MAX)) begin
            cfg.order = ORD_W'(order_code);
        end else begin
            cfg.ok = 1'b0;
        end
        if (af_en) begin
            if (af_ratio == 2'd0) cfg.ok = 1'b0;
            else                  cfg.k  = K_W'(af_ratio) + K_W'(AF_K_BASE);
        end else if (ratio_code >= 4'd1 && ratio_code <= RCODE_MAX) begin
            cfg.k = K_W'(ratio_code) + K_W'(LOG2_RMIN - 1);
        end else begin
            cfg.ok = 1'b0;
        end
    end
endmodule

// File: rtl/sinc_integrator.sv
module sinc_integrator #(
    parameter int N_STG = 5,
    parameter int ACC_W = 42,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             pdm_bit,
    input  logic [SEL_W-1:0] order,
    output logic [ACC_W-1:0] tap_next
);
    logic signed [ACC_W-1:0] acc_v [N_STG];
    logic signed [ACC_W-1:0] nxt   [N_STG];

    // one-cycle ripple through all stages: exact N-fold running sum
    always_comb begin
        logic signed [ACC_W-1:0] run;
        run = pdm_bit ? ACC_W'(1) : '1;
        for (int i = 0; i < N_STG; i++) begin
            run    = acc_v[i] + run;
            nxt[i] = run;
        end
    end

    always_comb begin
        tap_next = nxt[0];
        for (int i = 0; i < N_STG; i++) begin
            if (order == SEL_W'(i + 1)) tap_next = nxt[i];
        end
    end

    for (genvar i = 0; i < N_STG; i++) begin : g_stg
        logic signed [ACC_W-1:0] acc_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                  acc_q <= '0;
            else if (en && SEL_W'(i) < order)   acc_q <= nxt[i];
        end
        assign acc_v[i] = acc_q;
    end
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
    parameter int N_STG = 5,
    parameter int ACC_W = 42,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [ACC_W-1:0] din,
    input  logic [SEL_W-1:0] order,
    output logic [ACC_W-1:0] dout
);
    logic [ACC_W-1:0] dly_v  [N_STG];
    logic [ACC_W-1:0] stg_in [N_STG];
    logic [ACC_W-1:0] diff   [N_STG];

    always_comb begin
        logic [ACC_W-1:0] run;
        run = din;
        for (int i = 0; i < N_STG; i++) begin
            stg_in[i] = run;
            run       = run - dly_v[i];
            diff[i]   = run;
        end
    end

    always_comb begin
        dout = diff[0];
        for (int i = 0; i < N_STG; i++) begin
            if (order == SEL_W'(i + 1)) dout = diff[i];
        end
    end

    for (genvar i = 0; i < N_STG; i++) begin : g_stg
        logic [ACC_W-1:0] dly_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                  dly_q <= '0;
            else if (en && SEL_W'(i) < order)   dly_q <= stg_in[i];
        end
        assign dly_v[i] = dly_q;
    end
endmodule

// File: rtl/sinc_scale.sv
module sinc_scale #(
    parameter int ACC_W = 42,
    parameter int OUT_W = 24,
    parameter int NK_W  = 6
) (
    input  logic [ACC_W-1:0] din,
    input  logic [NK_W-1:0]  nk,
    output logic [OUT_W-1:0] dout
);
    localparam logic [NK_W-1:0]        TOP_BIT = NK_W'(OUT_W - 1);
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] NEG_LIM = -ACC_W'(2 ** (OUT_W - 1));

    logic signed [ACC_W-1:0] sdin;
    logic signed [ACC_W-1:0] v;

    assign sdin = din;

    always_comb begin
        if (nk >= TOP_BIT) v = sdin >>> (nk - TOP_BIT);
        else               v = sdin <<< (TOP_BIT - nk);
        if (v > POS_LIM)      dout = POS_LIM[OUT_W-1:0];
        else if (v < NEG_LIM) dout = NEG_LIM[OUT_W-1:0];
        else                  dout = v[OUT_W-1:0];
    end
endmodule

// File: rtl/pdm_sinc_decim.sv
module pdm_sinc_decim
    import pdm_sinc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdm_bit,
    input  logic             pdm_valid,
    input  logic [3:0]       order_code,
    input  logic [3:0]       ratio_code,
    input  logic             af_en,
    input  logic [1:0]       af_ratio,
    output logic [OUT_W-1:0] pcm_data,
    output logic             pcm_valid
);
    sinc_state_e      state_q, state_d;
    sinc_cfg_t        cfg_in, cfg_q;
    logic             cfg_chg;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic             blk_last;
    logic             integ_en;
    logic             emit;
    logic [ACC_W-1:0] tap_next, snap_q, comb_out;
    logic [NK_W-1:0]  nk;
    logic [OUT_W-1:0] scaled;
    logic [OUT_W-1:0] pcm_data_q;
    logic             pcm_valid_q;

    sinc_cfg_decode u_dec (
        .order_code (order_code),
        .ratio_code (ratio_code),
        .af_en      (af_en),
        .af_ratio   (af_ratio),
        .cfg        (cfg_in)
    );

    assign cfg_chg  = (cfg_in != cfg_q);
    assign span     = (CNT_W + 1)'(1) << cfg_q.k;
    assign blk_last = (cnt_q == CNT_W'(span - 1'b1));
    assign integ_en = pdm_valid && !cfg_chg && (state_q != ST_OFF);
    assign emit     = (state_q == ST_EMIT) && !cfg_chg;
    assign nk       = NK_W'(cfg_q.order) * NK_W'(cfg_q.k);

    sinc_integrator #(.N_STG(ORDER_MAX), .ACC_W(ACC_W), .SEL_W(ORD_W)) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_chg),
        .en       (integ_en),
        .pdm_bit  (pdm_bit),
        .order    (cfg_q.order),
        .tap_next (tap_next)
    );

    sinc_comb #(.N_STG(ORDER_MAX), .ACC_W(ACC_W), .SEL_W(ORD_W)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_chg),
        .en    (emit),
        .din   (snap_q),
        .order (cfg_q.order),
        .dout  (comb_out)
    );

    sinc_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .NK_W(NK_W)) u_scale (
        .din  (comb_out),
        .nk   (nk),
        .dout (scaled)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg_chg) begin
            state_d = cfg_in.ok ? ST_ACC : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_OFF;
                ST_ACC:  if (pdm_valid && blk_last) state_d = ST_EMIT;
                ST_EMIT: state_d = ST_ACC;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register and block bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cfg_q   <= CFG_RST;
            cnt_q   <= '0;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_in;
            if (cfg_chg) begin
                cnt_q  <= '0;
                snap_q <= '0;
            end else if (integ_en) begin
                cnt_q <= blk_last ? '0 : cnt_q + 1'b1;
                if (state_q == ST_ACC && blk_last) snap_q <= tap_next;
            end
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcm_valid_q <= 1'b0;
            pcm_data_q  <= '0;
        end else begin
            pcm_valid_q <= emit;
            if (emit) pcm_data_q <= scaled;
        end
    end

    assign pcm_data  = pcm_data_q;
    assign pcm_valid = pcm_valid_q;
endmodule

// File: rtl/pdm_sinc_decim_chk.sv
module pdm_sinc_decim_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pdm_valid,
    input logic [3:0]  order_code,
    input logic [3:0]  ratio_code,
    input logic        af_en,
    input logic [1:0]  af_ratio,
    input logic [23:0] pcm_data,
    input logic        pcm_valid
);
    logic       bad;
    logic [2:0] ord_e;
    logic [3:0] rat_e;
    logic [7:0] key;

    assign ord_e = (order_code == 4'd0) ? 3'd3 : order_code[2:0];
    assign rat_e = af_en ? ({2'b00, af_ratio} + 4'd3) : ratio_code;
    assign bad   = (order_code > 4'd5) || (af_en ? (af_ratio == 2'd0)
                                                 : (ratio_code == 4'd0 || ratio_code > 4'd6));
    assign key   = {bad, ord_e, rat_e};

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid);

    // R10
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> $past(pdm_valid, 2));

    // R4
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && $past(bad)) |-> !pcm_valid);

    // R9
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key != $past(key)) |=> !pcm_valid);

    // R11
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_valid |-> $stable(pcm_data));
endmodule

bind pdm_sinc_decim pdm_sinc_decim_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdm_valid  (pdm_valid),
    .order_code (order_code),
    .ratio_code (ratio_code),
    .af_en      (af_en),
    .af_ratio   (af_ratio),
    .pcm_data   (pcm_data),
    .pcm_valid  (pcm_valid)
);

// File: tb/pdm_sinc_decim_tb.sv
module pdm_sinc_decim_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;
    localparam int NVEC       = 15;

    // fields: req(4) ord(4) rat(4) af(1) afr(2) pat(8) gap(1) idx(4) exp(24)
    localparam logic [51:0] VECS [NVEC] = '{
        {4'd2, 4'd1, 4'd1, 1'b0, 2'd0, 8'hFF, 1'b0, 4'd1, 24'h7FFFFF}, // R2 clamp high
        {4'd2, 4'd1, 4'd1, 1'b0, 2'd0, 8'h00, 1'b0, 4'd1, 24'h800000}, // R2 low end
        {4'd1, 4'd1, 4'd1, 1'b0, 2'd0, 8'h3F, 1'b0, 4'd2, 24'h400000}, // R1 density 6/8
        {4'd1, 4'd1, 4'd2, 1'b0, 2'd0, 8'h55, 1'b0, 4'd1, 24'h000000}, // R1 alternating
        {4'd6, 4'd2, 4'd1, 1'b0, 2'd0, 8'hFF, 1'b0, 4'd1, 24'h480000}, // R6 first, order 2
        {4'd6, 4'd2, 4'd1, 1'b0, 2'd0, 8'hFF, 1'b0, 4'd2, 24'h7FFFFF}, // R6 steady, order 2
        {4'd6, 4'd3, 4'd1, 1'b0, 2'd0, 8'hFF, 1'b0, 4'd1, 24'h1E0000}, // R6 first, order 3
        {4'd1, 4'd3, 4'd1, 1'b0, 2'd0, 8'h00, 1'b0, 4'd3, 24'h800000}, // R1 order 3 steady
        {4'd3, 4'd0, 4'd1, 1'b0, 2'd0, 8'hFF, 1'b0, 4'd1, 24'h1E0000}, // R3 default order
        {4'd7, 4'd5, 4'd6, 1'b0, 2'd0, 8'hFF, 1'b0, 4'd5, 24'h7FFFFF}, // R7 order 5 R256 high
        {4'd7, 4'd5, 4'd6, 1'b0, 2'd0, 8'h00, 1'b0, 4'd5, 24'h800000}, // R7 order 5 R256 low
        {4'd5, 4'd1, 4'd0, 1'b1, 2'd1, 8'h7F, 1'b0, 4'd1, 24'h600000}, // R5 af R64
        {4'd5, 4'd1, 4'd1, 1'b1, 2'd3, 8'h7F, 1'b0, 4'd1, 24'h600000}, // R5 af R256
        {4'd8, 4'd2, 4'd3, 1'b0, 2'd0, 8'h01, 1'b1, 4'd2, 24'hA00000}, // R8 gapped strobe
        {4'd4, 4'd1, 4'd5, 1'b0, 2'd0, 8'h03, 1'b0, 4'd1, 24'hC00000}  // R4 ratio 128
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pdm_bit = 1'b0;
    logic        pdm_valid = 1'b0;
    logic [3:0]  order_code = 4'd1;
    logic [3:0]  ratio_code = 4'd1;
    logic        af_en = 1'b0;
    logic [1:0]  af_ratio = 2'd0;
    logic [23:0] pcm_data;
    logic        pcm_valid;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    pdm_sinc_decim u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pdm_bit    (pdm_bit),
        .pdm_valid  (pdm_valid),
        .order_code (order_code),
        .ratio_code (ratio_code),
        .af_en      (af_en),
        .af_ratio   (af_ratio),
        .pcm_data   (pcm_data),
        .pcm_valid  (pcm_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            n_bad = n_bad + 1;
            $display("FAIL R10 watchdog: got %0d cycles, expected below %0d", cyc, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        pdm_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_cfg(input logic [3:0] o, input logic [3:0] r,
                           input logic a, input logic [1:0] ar);
        order_code = o;
        ratio_code = r;
        af_en      = a;
        af_ratio   = ar;
        pdm_valid  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // sample outputs, then drive the next bit, at each falling edge
    task automatic feed(input logic [7:0] pat, input logic gap, input int idx,
                        input int maxcyc, output logic [23:0] got, output int nout);
        int s;
        s    = 0;
        nout = 0;
        got  = '0;
        for (int c = 0; c < maxcyc && nout < idx; c++) begin
            @(negedge clk);
            if (pcm_valid) begin
                nout = nout + 1;
                if (nout == idx) got = pcm_data;
            end
            if (gap && (c % 2 == 1)) begin
                pdm_valid = 1'b0;
            end else begin
                pdm_valid = 1'b1;
                pdm_bit   = pat[s % 8];
                s = s + 1;
            end
        end
        pdm_valid = 1'b0;
    endtask

    initial begin
        logic [23:0] got;
        int          nout;

        // R12: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 valid in reset", {31'd0, pcm_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 data after reset", {8'd0, pcm_data}, 32'd0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [51:0] e;
            string       tag;
            e = VECS[v];
            do_reset();
            set_cfg(e[47:44], e[43:40], e[39], e[38:37]);
            feed(e[36:29], e[28], int'(e[27:24]), 4000, got, nout);
            tag = $sformatf("R%0d vector %0d", e[51:48], v);
            chk(tag, nout, int'(e[27:24]));
            chk(tag, {8'd0, got}, {8'd0, e[23:0]});
        end

        // R4: ratio code 7 is silent
        do_reset();
        set_cfg(4'd1, 4'd7, 1'b0, 2'd0);
        feed(8'hFF, 1'b0, 1, 600, got, nout);
        chk("R4 ratio code 7 count", nout, 0);

        // R3: order code 6 is silent
        do_reset();
        set_cfg(4'd6, 4'd1, 1'b0, 2'd0);
        feed(8'hFF, 1'b0, 1, 600, got, nout);
        chk("R3 order code 6 count", nout, 0);

        // R5: af_ratio 0 is silent even with a valid ratio_code
        do_reset();
        set_cfg(4'd1, 4'd1, 1'b1, 2'd0);
        feed(8'hFF, 1'b0, 1, 600, got, nout);
        chk("R5 af ratio 0 count", nout, 0);

        // R9: settings change wipes history and drops the change-cycle bit
        do_reset();
        set_cfg(4'd1, 4'd1, 1'b0, 2'd0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pdm_valid = 1'b1;
            pdm_bit   = 1'b1;
        end
        @(negedge clk);
        ratio_code = 4'd2;
        pdm_valid  = 1'b1;
        pdm_bit    = 1'b1;
        feed(8'h00, 1'b0, 1, 200, got, nout);
        chk("R9 count after change", nout, 1);
        chk("R9 first sample after change", {8'd0, got}, 32'h00800000);

        // R10 / R11: pulse timing and hold
        do_reset();
        set_cfg(4'd1, 4'd1, 1'b0, 2'd0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pdm_valid = 1'b1;
            pdm_bit   = 1'b1;
        end
        @(negedge clk);
        pdm_valid = 1'b0;
        chk("R10 no pulse one edge after last bit", {31'd0, pcm_valid}, 32'd0);
        @(negedge clk);
        chk("R10 pulse two edges after last bit", {31'd0, pcm_valid}, 32'd1);
        chk("R10 sample value", {8'd0, pcm_data}, 32'h007FFFFF);
        @(negedge clk);
        chk("R10 pulse lasts one cycle", {31'd0, pcm_valid}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R11 data held", {8'd0, pcm_data}, 32'h007FFFFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule